// File: doc/BRIEF.md
# Smoothed Delay-Time Controller

This block turns a stream of 10-bit potentiometer conversions into the delay length that an audio delay line uses. Each group of 256 valid conversions is summed, and the sum is scaled into a 16-bit candidate. The candidate becomes the new target only if it lies at least 0x40 away from the current target. This deadband keeps converter jitter from moving the delay. The stored target is always even.

The delay actually in use does not jump to the target. On every audio sample strobe it moves toward the target: up by two or down by one. The delay line therefore speeds up or slows down smoothly and does not click. The block also forms the read address for the delay memory from the write address. The delay region sits a fixed 256 entries behind the write pointer, and the read address sits a further delay-in-use entries behind that. The converter and the memory are outside the block.

Top module: `dly_slew_ctrl`

## Requirements
- R1: After reset the delay in use and the target are both 0, so `delay_out` reads 0.
- R2: Only cycles with `conv_vld` high add `conv_data` to the sum. When the 256th valid conversion arrives, the unsigned sum of the 256 conversions is shifted right by 2 to form a 16-bit candidate.
- R3: The candidate replaces the target only when the absolute difference between candidate and current target is 0x40 or more. A difference of 0x3F or less leaves the target unchanged.
- R4: When the target is replaced, bit 0 of the new target is 0 (candidate with its least significant bit cleared).
- R5: After each evaluation the sum and the conversion count restart from zero, whether the target was replaced or not.
- R6: On each cycle with `smp_stb` high, `delay_out` increases by 2 if it is below the target, decreases by 1 if it is above, and is unchanged if it is equal. The new value shows one clock after the strobe.
- R7: Without `smp_stb`, `delay_out` does not change, even while it differs from the target.
- R8: `rd_addr` equals `wr_addr - 256 - delay_out`, wrapping modulo 2^16, combinationally from the current inputs and state.
- R9: The absolute difference is formed with one extra bit, so candidate 0xFFC0 against target 0 counts as a large difference and is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_vld | input | 1 | Conversion result valid this cycle |
| conv_data | input | 10 | Unsigned conversion result |
| smp_stb | input | 1 | One-cycle audio sample strobe |
| wr_addr | input | 16 | Current delay-memory write address |
| delay_out | output | 16 | Delay length in use |
| rd_addr | output | 16 | Delay-memory read address |

## Verification
Groups of constant conversions are mixed with groups that carry a deliberate offset on one sample, so that candidates land exactly 0x3F and 0x40 from the target. This separates a correct deadband threshold from an off-by-one threshold. A ramp pattern and a group with idle gaps on `conv_vld` show that the sum counts valid cycles only and starts afresh after every evaluation. Strobe runs stop on odd delay values and are then given a higher target. This separates the asymmetric up-2/down-1 slew, including its overshoot by one, from a symmetric one. Full-scale jumps from 0 to 0xFFC0 and back test that the magnitude comparison does not wrap. The write address crosses 0xFFFF, which tests the wrap of the read address.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
   parameter int unsigned DSC_CONV_W   = 10;
   parameter int unsigned DSC_DLY_W    = 16;
   parameter int unsigned DSC_OVS_LOG2 = 8;

   typedef enum logic [1:0] {
      SLEW_HOLD = 2'd0,
      SLEW_UP   = 2'd1,
      SLEW_DOWN = 2'd2
   } slew_dir_e;
endpackage

// File: rtl/dsc_ovs_acc.sv
module dsc_ovs_acc #(
   parameter int unsigned CONV_W   = dsc_pkg::DSC_CONV_W,
   parameter int unsigned OVS_LOG2 = dsc_pkg::DSC_OVS_LOG2,
   parameter int unsigned SHIFT    = 2,
   parameter int unsigned OUT_W    = dsc_pkg::DSC_DLY_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_vld,
   input  logic [CONV_W-1:0] conv_data,
   output logic              avg_vld,
   output logic [OUT_W-1:0]  avg_val
);
   localparam int unsigned ACC_W = CONV_W + OVS_LOG2;

   if (OVS_LOG2 < 1) begin : g_bad_ovs
      $error("dsc_ovs_acc: OVS_LOG2 must be at least 1");
   end
   if (ACC_W - SHIFT > OUT_W) begin : g_bad_width
      $error("dsc_ovs_acc: scaled sum does not fit OUT_W");
   end

   logic [ACC_W-1:0]    acc_q;
   logic [ACC_W-1:0]    acc_nxt;
   logic [OVS_LOG2-1:0] cnt_q;
   logic                grp_last;

   assign acc_nxt  = acc_q + ACC_W'(conv_data);
   assign grp_last = conv_vld && (cnt_q == '1);

   // R2, R5: sum one group, hand the scaled result on, restart from zero
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q   <= '0;
         cnt_q   <= '0;
         avg_vld <= 1'b0;
         avg_val <= '0;
      end else begin
         avg_vld <= grp_last;
         if (conv_vld) begin
            if (grp_last) begin
               acc_q   <= '0;
               cnt_q   <= '0;
               avg_val <= OUT_W'(acc_nxt >> SHIFT);
            end else begin
               acc_q <= acc_nxt;
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/dsc_deadband.sv
module dsc_deadband #(
   parameter int unsigned W        = dsc_pkg::DSC_DLY_W,
   parameter int unsigned DEADBAND = 16'h0040,
   parameter bit          FORCE_EVEN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         avg_vld,
   input  logic [W-1:0] avg_val,
   output logic [W-1:0] tgt
);
   if (DEADBAND >= (1 << W)) begin : g_bad_db
      $error("dsc_deadband: DEADBAND exceeds value range");
   end

   logic signed [W:0] diff;
   logic        [W:0] mag;
   logic              accept;
   logic [W-1:0]      tgt_new;

   // R9: one extra bit so the magnitude never wraps
   assign diff   = $signed({1'b0, avg_val}) - $signed({1'b0, tgt});
   assign mag    = diff[W] ? (W+1)'(-diff) : (W+1)'(diff);
   assign accept = (mag >= (W+1)'(DEADBAND));

   // R4: variant choice for the stored least significant bit
   if (FORCE_EVEN) begin : g_even
      assign tgt_new = {avg_val[W-1:1], 1'b0};
   end else begin : g_raw
      assign tgt_new = avg_val;
   end

   // R1, R3
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tgt <= '0;
      end else if (avg_vld && accept) begin
         tgt <= tgt_new;
      end
   end
endmodule

// File: rtl/dsc_slew.sv
module dsc_slew #(
   parameter int unsigned W       = dsc_pkg::DSC_DLY_W,
   parameter int unsigned STEP_UP = 2,
   parameter int unsigned STEP_DN = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         smp_stb,
   input  logic [W-1:0] tgt,
   output logic [W-1:0] cur
);
   import dsc_pkg::*;

   if (STEP_UP < 1 || STEP_DN < 1) begin : g_bad_step
      $error("dsc_slew: steps must be non-zero");
   end

   slew_dir_e dir;

   always_comb begin
      if (cur < tgt)      dir = SLEW_UP;
      else if (cur > tgt) dir = SLEW_DOWN;
      else                dir = SLEW_HOLD;
   end

   // R1, R6, R7
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur <= '0;
      end else if (smp_stb) begin
         case (dir)
            SLEW_UP:   cur <= cur + W'(STEP_UP);
            SLEW_DOWN: cur <= cur - W'(STEP_DN);
            default:   cur <= cur;
         endcase
      end
   end
endmodule

// File: rtl/dsc_rdaddr.sv
module dsc_rdaddr #(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned DLY_W      = dsc_pkg::DSC_DLY_W,
   parameter int unsigned REGION_OFS = 256
) (
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DLY_W-1:0]  dly,
   output logic [ADDR_W-1:0] rd_addr
);
   if (DLY_W > ADDR_W) begin : g_bad_addr
      $error("dsc_rdaddr: delay wider than address");
   end

   // R8: modulo 2^ADDR_W arithmetic
   if (REGION_OFS == 0) begin : g_no_ofs
      assign rd_addr = wr_addr - ADDR_W'(dly);
   end else begin : g_ofs
      assign rd_addr = wr_addr - ADDR_W'(REGION_OFS) - ADDR_W'(dly);
   end
endmodule

// File: rtl/dly_slew_ctrl.sv
module dly_slew_ctrl #(
   parameter int unsigned CONV_W     = dsc_pkg::DSC_CONV_W,
   parameter int unsigned OVS_LOG2   = dsc_pkg::DSC_OVS_LOG2,
   parameter int unsigned SHIFT      = 2,
   parameter int unsigned DLY_W      = dsc_pkg::DSC_DLY_W,
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned DEADBAND   = 16'h0040,
   parameter bit          FORCE_EVEN = 1'b1,
   parameter int unsigned STEP_UP    = 2,
   parameter int unsigned STEP_DN    = 1,
   parameter int unsigned REGION_OFS = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_vld,
   input  logic [CONV_W-1:0] conv_data,
   input  logic              smp_stb,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic [DLY_W-1:0]  delay_out,
   output logic [ADDR_W-1:0] rd_addr
);
   logic             avg_vld;
   logic [DLY_W-1:0] avg_val;
   logic [DLY_W-1:0] tgt_q;

   dsc_ovs_acc #(
      .CONV_W(CONV_W), .OVS_LOG2(OVS_LOG2), .SHIFT(SHIFT), .OUT_W(DLY_W)
   ) u_acc (
      .clk(clk), .rst_n(rst_n), .conv_vld(conv_vld), .conv_data(conv_data),
      .avg_vld(avg_vld), .avg_val(avg_val)
   );

   dsc_deadband #(
      .W(DLY_W), .DEADBAND(DEADBAND), .FORCE_EVEN(FORCE_EVEN)
   ) u_db (
      .clk(clk), .rst_n(rst_n), .avg_vld(avg_vld), .avg_val(avg_val), .tgt(tgt_q)
   );

   dsc_slew #(
      .W(DLY_W), .STEP_UP(STEP_UP), .STEP_DN(STEP_DN)
   ) u_slew (
      .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .tgt(tgt_q), .cur(delay_out)
   );

   dsc_rdaddr #(
      .ADDR_W(ADDR_W), .DLY_W(DLY_W), .REGION_OFS(REGION_OFS)
   ) u_rd (
      .wr_addr(wr_addr), .dly(delay_out), .rd_addr(rd_addr)
   );
endmodule

// File: rtl/dsc_chk.sv
module dsc_chk #(
   parameter int unsigned DLY_W      = 16,
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned REGION_OFS = 256,
   parameter int unsigned STEP_UP    = 2,
   parameter int unsigned STEP_DN    = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              smp_stb,
   input logic              avg_vld,
   input logic [DLY_W-1:0]  tgt,
   input logic [DLY_W-1:0]  delay_out,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [ADDR_W-1:0] rd_addr
);
   AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_stb |=> $stable(delay_out)); // R7

   AST_SLEW_UP: assert property (@(posedge clk) disable iff (!rst_n)
      smp_stb && (delay_out < tgt) |=> delay_out == DLY_W'($past(delay_out) + DLY_W'(STEP_UP))); // R6

   AST_SLEW_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      smp_stb && (delay_out > tgt) |=> delay_out == DLY_W'($past(delay_out) - DLY_W'(STEP_DN))); // R6

   AST_TGT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !avg_vld |=> $stable(tgt)); // R3

   AST_TGT_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      tgt[0] == 1'b0); // R4

   AST_RD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      rd_addr == ADDR_W'(wr_addr - ADDR_W'(REGION_OFS) - ADDR_W'(delay_out))); // R8
endmodule

bind dly_slew_ctrl dsc_chk #(
   .DLY_W(DLY_W), .ADDR_W(ADDR_W), .REGION_OFS(REGION_OFS),
   .STEP_UP(STEP_UP), .STEP_DN(STEP_DN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .avg_vld(avg_vld), .tgt(tgt_q),
   .delay_out(delay_out), .wr_addr(wr_addr), .rd_addr(rd_addr)
);

// File: tb/dly_slew_ctrl_tb_top.sv
module dly_slew_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        conv_vld = 1'b0;
   logic [9:0]  conv_data = '0;
   logic        smp_stb = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [15:0] delay_out;
   logic [15:0] rd_addr;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   int tgt_m = 0;
   int cur_m = 0;
   logic [15:0] exp_dly_q[$];
   logic [15:0] exp_rd_q[$];
   logic chk_pend = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dly_slew_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .conv_vld(conv_vld), .conv_data(conv_data),
      .smp_stb(smp_stb), .wr_addr(wr_addr), .delay_out(delay_out), .rd_addr(rd_addr)
   );

   task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // monitor: one scoreboard item per strobe, compared half a clock after the update edge
   always @(posedge clk) chk_pend <= smp_stb;
   always @(negedge clk) begin
      if (chk_pend) begin
         if (exp_dly_q.size() == 0) begin
            check16("R6 scoreboard underflow", 16'h0, 16'h1);
         end else begin
            check16("R6 delay after strobe", delay_out, exp_dly_q.pop_front());
            check16("R8 read address", rd_addr, exp_rd_q.pop_front());
         end
      end
   end

   // driver: 256 valid conversions, value base plus extra on the first one; ramp adds i*13
   task automatic run_group(input int base, input int extra, input bit ramp, input bit gaps);
      int sum = 0;
      int cand;
      int diff;
      for (int i = 0; i < 256; i++) begin
         int v;
         v = ramp ? ((i * 13) % 1024) : base;
         if (i == 0) v = v + extra;
         sum += v;
         @(posedge clk); #1;
         conv_vld  = 1'b1;
         conv_data = 10'(v);
         if (gaps) begin
            @(posedge clk); #1;
            conv_vld  = 1'b0;
            conv_data = 10'h3FF;
         end
      end
      @(posedge clk); #1;
      conv_vld = 1'b0;
      conv_data = 10'h3FF;
      cand = (sum >> 2) & 16'hFFFF;
      diff = cand - tgt_m;
      if (diff < 0) diff = -diff;
      if (diff >= 64) tgt_m = cand & 16'hFFFE;
      repeat (3) @(posedge clk);
      #1;
   endtask

   task automatic strobe(input int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk); #1;
         smp_stb = 1'b1;
         wr_addr = wr_addr + 16'd1;
         if (cur_m < tgt_m) cur_m += 2;
         else if (cur_m > tgt_m) cur_m -= 1;
         exp_dly_q.push_back(16'(cur_m));
         exp_rd_q.push_back(16'(wr_addr - 16'd256 - 16'(cur_m)));
         @(posedge clk); #1;
         smp_stb = 1'b0;
      end
      repeat (2) @(posedge clk);
      #1;
   endtask

   task automatic idle_hold(input string tag);
      repeat (20) @(posedge clk);
      @(negedge clk);
      check16(tag, delay_out, 16'(cur_m));
      @(posedge clk); #1;
   endtask

   initial begin
      wr_addr = 16'h0000;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check16("R1 reset delay", delay_out, 16'h0000);
      check16("R8 reset read address", rd_addr, 16'hFF00);
      wr_addr = 16'hF000;

      run_group(100, 0, 1'b0, 1'b0);          // R2 candidate 6400 accepted
      idle_hold("R7 no strobe keeps delay");
      strobe(3300);                            // R6 climb and hold
      check16("R2 settled on 6400", delay_out, 16'd6400);

      run_group(100, 252, 1'b0, 1'b0);        // R3 difference 0x3F rejected
      strobe(10);
      check16("R3 small change ignored", delay_out, 16'd6400);

      run_group(101, 0, 1'b0, 1'b0);          // R3 difference 0x40 accepted, R5 fresh sum
      strobe(40);
      check16("R3 threshold accepted", delay_out, 16'd6464);

      run_group(99, 6, 1'b0, 1'b1);           // R4 odd candidate 6337, R2 gaps ignored
      strobe(65);                              // stops on odd 6399
      check16("R4 even target approached", delay_out, 16'd6399);

      run_group(110, 0, 1'b0, 1'b0);          // R6 overshoot by one from odd value
      strobe(330);
      check16("R6 settles after overshoot", delay_out, 16'd7040);

      run_group(0, 0, 1'b1, 1'b0);            // R2 ramp pattern, R5
      strobe(600);

      run_group(1023, 0, 1'b0, 1'b0);         // R9 full-scale candidate 0xFFC0
      idle_hold("R7 hold after full-scale target");
      strobe(300);
      run_group(0, 0, 1'b0, 1'b0);            // R9 back to zero
      strobe(300);
      check16("R9 queue drained", 16'(exp_dly_q.size()), 16'h0);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual running expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule